// File: doc/BRIEF.md
# DSI Video-Mode Timing Generator

This block sequences lines and frames for a display serial link running video mode in burst-with-sync-pulses form. It runs on the lane byte clock. Horizontal timing is counted in byte-clock cycles: sync-active time, back-porch time, the time the pixel burst occupies, and the total line time. The front porch is whatever is left of the line. Vertical timing is counted in lines, and each frame runs sync-active lines, then back-porch lines, then active lines, then front-porch lines. A region of zero lines is skipped without any idle line.

The generator reports the current vertical and horizontal region. It emits strobes for line start, end of horizontal sync, frame start, end of vertical sync, one pixel-packet request per active line carrying the packet size, and a turnaround-acknowledge request at the end of each frame. It also raises a flag in every blanking interval where a 6-bit mask lets the link drop to low power. All configuration comes from plain input ports. The generator takes a new configuration only when it starts from idle or at a frame boundary. It refuses a configuration that breaks the limits below.

The packet request is a one-cycle valid strobe with no ready. The timing is fixed by the line counter, so the packet assembler downstream must accept the request in the cycle it is raised. Back-pressure is not possible.

Top module: `dsi_vid_timing`

## Requirements
- R1: After reset, with enable low, `active`, both region outputs and every strobe and flag are 0.
- R2: Each line lasts `cfg_hline` cycles, counted from the line-start cycle. `hregion` is 0 (sync) for the first `cfg_hsa` cycles and then 1 (back porch) for `cfg_hbp` cycles. On active lines it is then 2 (active burst) for `cfg_hact` cycles. It is 3 (front porch) for the rest of the line.
- R3: `vregion` goes 0 (sync) for `cfg_vsa` lines, 1 (back porch) for `cfg_vbp` lines, 2 (active) for `cfg_vact` lines and 3 (front porch) for `cfg_vfp` lines, and then the next frame starts. A region of zero lines is skipped.
- R4: `pkt_valid` pulses for exactly one cycle, in the first burst cycle of every active line, and never on any other line. With it, `pkt_size` equals `cfg_pixels`.
- R5: `lp_allowed` is 0 in horizontal sync and in the active burst. During a blanking region it equals the mask bit for that region. Bit 0 covers sync lines, bit 1 back-porch lines and bit 2 front-porch lines. On active lines, bit 3 covers the back porch and bit 4 the front porch, except on the last active line, where bit 5 covers the front porch.
- R6: A configuration is accepted only when all of these hold: `cfg_mode` is 2, `cfg_vact` ≤ 0x7FF, `cfg_pixels` ≤ 0x7FF, `cfg_hact` ≥ 1, `cfg_hline` > hsa+hbp+hact, and the frame has at least one line. `cfg_err` shows that the present inputs are refused. A refused configuration never starts the generator, and at a frame boundary it sends the generator to idle.
- R7: A configuration change in the middle of a frame takes effect only from the next frame.
- R8: With enable low, `active` is 0 on the next cycle. A later start begins again at the first line of a frame.
- R9: When `cfg_bta_ack` was set for the frame, `bta_req` pulses in the last cycle of each frame.
- R10: `line_start` pulses in the first cycle of every line. `sync_end` pulses in the first cycle after horizontal sync, which is the line-start cycle when sync is zero. `frame_start` pulses in the first cycle of a frame. `vsync_end` pulses in the first cycle of the first line after the vertical sync lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; low forces idle |
| cfg_mode | input | 2 | Video mode type; only 2 is accepted |
| cfg_hsa | input | H_W | Horizontal sync cycles |
| cfg_hbp | input | H_W | Horizontal back-porch cycles |
| cfg_hact | input | H_W | Active burst cycles |
| cfg_hline | input | H_W | Total line cycles |
| cfg_vsa | input | V_W | Vertical sync lines |
| cfg_vbp | input | V_W | Vertical back-porch lines |
| cfg_vact | input | V_W | Active lines |
| cfg_vfp | input | V_W | Vertical front-porch lines |
| cfg_pixels | input | P_W | Pixel packet size |
| cfg_lp_mask | input | 6 | Per-region low-power permission |
| cfg_bta_ack | input | 1 | Request turnaround acknowledge at frame end |
| active | output | 1 | Generator running |
| cfg_err | output | 1 | Present configuration refused |
| vregion | output | 2 | Vertical region code |
| hregion | output | 2 | Horizontal region code |
| line_start | output | 1 | First cycle of a line |
| sync_end | output | 1 | First cycle after horizontal sync |
| frame_start | output | 1 | First cycle of a frame |
| vsync_end | output | 1 | First cycle after the vertical sync lines |
| pkt_valid | output | 1 | Pixel packet request |
| pkt_size | output | P_W | Packet size, valid with pkt_valid |
| lp_allowed | output | 1 | Link may drop to low power |
| bta_req | output | 1 | Frame-end turnaround request |

## Verification
Some properties are checked on every cycle. The line counter stays below the line length and the line index stays below the length of its region. Packet requests occur only on active lines. Low power is never allowed during horizontal sync. The shadow configuration holds still inside a frame. A refused configuration never leaves the idle state. Dropping enable reaches idle in one cycle, and a frame-end request is followed by a new frame or by idle. The exact region boundaries, the skipping of empty regions, the choice of mask bit on the last active line and the point where a new configuration takes effect can only be shown by the bench. It sweeps small configurations and compares every cycle against the timing worked out by arithmetic.

// File: rtl/dsi_vtg_pkg.sv
package dsi_vtg_pkg;
  localparam logic [1:0] V_SYNC  = 2'd0;
  localparam logic [1:0] V_BACK  = 2'd1;
  localparam logic [1:0] V_ACT   = 2'd2;
  localparam logic [1:0] V_FRONT = 2'd3;
  localparam logic [1:0] H_SYNC  = 2'd0;
  localparam logic [1:0] H_BACK  = 2'd1;
  localparam logic [1:0] H_ACT   = 2'd2;
  localparam logic [1:0] H_FRONT = 2'd3;
  localparam logic [1:0] MODE_BURST_PULSES = 2'd2;

  // lowest non-empty region at or after 'from'
  function automatic logic region_found(input logic [3:0] nz, input logic [2:0] from);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 4; i++) if (nz[i] && 3'(i) >= from) r = 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] region_pick(input logic [3:0] nz, input logic [2:0] from);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 3; i >= 0; i--) if (nz[i] && 3'(i) >= from) r = 2'(i);
    return r;
  endfunction
endpackage

// File: rtl/dsi_vtg_cfg.sv
module dsi_vtg_cfg
  import dsi_vtg_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12,
  parameter int P_W = 14,
  parameter int ACT_MAX = 2047
) (
  input  logic [1:0]     mode,
  input  logic [H_W-1:0] hsa,
  input  logic [H_W-1:0] hbp,
  input  logic [H_W-1:0] hact,
  input  logic [H_W-1:0] hline,
  input  logic [V_W-1:0] vsa,
  input  logic [V_W-1:0] vbp,
  input  logic [V_W-1:0] vact,
  input  logic [V_W-1:0] vfp,
  input  logic [P_W-1:0] pixels,
  output logic           ok
);
  localparam int SW = H_W + 2;
  logic [SW-1:0] busy_sum;
  logic lines_any;

  assign busy_sum  = SW'(hsa) + SW'(hbp) + SW'(hact);
  assign lines_any = (vsa != '0) || (vbp != '0) || (vact != '0) || (vfp != '0);
  assign ok = (mode == MODE_BURST_PULSES) &&
              (32'(vact) <= ACT_MAX) && (32'(pixels) <= ACT_MAX) &&
              (hact != '0) && (busy_sum < SW'(hline)) && lines_any;
endmodule

// File: rtl/dsi_vtg_hline.sv
module dsi_vtg_hline
  import dsi_vtg_pkg::*;
#(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           in_act,
  input  logic [H_W-1:0] hsa,
  input  logic [H_W-1:0] hbp,
  input  logic [H_W-1:0] hact,
  input  logic [H_W-1:0] hline,
  output logic [1:0]     hreg,
  output logic           line_end,
  output logic           hs_start,
  output logic           hs_end,
  output logic           pkt_fire
);
  localparam int SW = H_W + 2;
  logic [H_W-1:0] hcnt;
  logic [SW-1:0]  b_sync, b_back, b_act, pos;

  assign pos    = SW'(hcnt);
  assign b_sync = SW'(hsa);
  assign b_back = b_sync + SW'(hbp);
  assign b_act  = b_back + SW'(hact);

  assign line_end = run && (hcnt == hline - H_W'(1));
  assign hs_start = run && (hcnt == '0);
  assign hs_end   = run && (hcnt == hsa);
  assign pkt_fire = run && in_act && (pos == b_back);

  always_comb begin
    if (pos < b_sync)                hreg = H_SYNC;
    else if (pos < b_back)           hreg = H_BACK;
    else if (in_act && pos < b_act)  hreg = H_ACT;
    else                             hreg = H_FRONT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hcnt <= '0;
    else if (!run)     hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + H_W'(1);
  end

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt < hline));
endmodule

// File: rtl/dsi_vtg_vframe.sv
module dsi_vtg_vframe
  import dsi_vtg_pkg::*;
#(
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           load,
  input  logic [1:0]     load_reg,
  input  logic           line_end,
  input  logic [V_W-1:0] vsa,
  input  logic [V_W-1:0] vbp,
  input  logic [V_W-1:0] vact,
  input  logic [V_W-1:0] vfp,
  output logic [1:0]     vreg,
  output logic           frame_end,
  output logic           last_act,
  output logic           at_top,
  output logic           left_sync
);
  logic [V_W-1:0] vcnt, len;
  logic [3:0]     nz;
  logic [2:0]     after;
  logic           nxt_ok, last_in_reg;
  logic [1:0]     nxt;

  assign nz = {vfp != '0, vact != '0, vbp != '0, vsa != '0};
  assign after = {1'b0, vreg} + 3'd1;
  assign nxt_ok = region_found(nz, after);
  assign nxt    = region_pick(nz, after);

  always_comb begin
    case (vreg)
      V_SYNC:  len = vsa;
      V_BACK:  len = vbp;
      V_ACT:   len = vact;
      default: len = vfp;
    endcase
  end

  assign last_in_reg = (vcnt == len - V_W'(1));
  assign frame_end   = run && line_end && last_in_reg && !nxt_ok;
  assign last_act    = (vreg == V_ACT) && last_in_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg <= V_SYNC; vcnt <= '0; at_top <= 1'b0; left_sync <= 1'b0;
    end else if (load) begin
      vreg <= load_reg; vcnt <= '0; at_top <= 1'b1; left_sync <= 1'b0;
    end else if (run && line_end) begin
      at_top <= 1'b0;
      if (last_in_reg) begin
        vcnt <= '0;
        if (nxt_ok) vreg <= nxt;
        left_sync <= (vreg == V_SYNC) && nxt_ok;
      end else begin
        vcnt <= vcnt + V_W'(1);
        left_sync <= 1'b0;
      end
    end
  end

  // R3
  vcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (vcnt < len));
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
  import dsi_vtg_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12,
  parameter int P_W = 14,
  parameter int ACT_MAX = 2047
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [1:0]     cfg_mode,
  input  logic [H_W-1:0] cfg_hsa,
  input  logic [H_W-1:0] cfg_hbp,
  input  logic [H_W-1:0] cfg_hact,
  input  logic [H_W-1:0] cfg_hline,
  input  logic [V_W-1:0] cfg_vsa,
  input  logic [V_W-1:0] cfg_vbp,
  input  logic [V_W-1:0] cfg_vact,
  input  logic [V_W-1:0] cfg_vfp,
  input  logic [P_W-1:0] cfg_pixels,
  input  logic [5:0]     cfg_lp_mask,
  input  logic           cfg_bta_ack,
  output logic           active,
  output logic           cfg_err,
  output logic [1:0]     vregion,
  output logic [1:0]     hregion,
  output logic           line_start,
  output logic           sync_end,
  output logic           frame_start,
  output logic           vsync_end,
  output logic           pkt_valid,
  output logic [P_W-1:0] pkt_size,
  output logic           lp_allowed,
  output logic           bta_req
);
  logic running, cfg_ok, load, frame_end, line_end, last_act, at_top, left_sync;
  logic hs_start, hs_end, pkt_fire, lp_raw;
  logic [1:0] vreg, hreg, first_reg;
  logic [H_W-1:0] sh_hsa, sh_hbp, sh_hact, sh_hline;
  logic [V_W-1:0] sh_vsa, sh_vbp, sh_vact, sh_vfp;
  logic [P_W-1:0] sh_pix;
  logic [5:0]     sh_mask;
  logic           sh_bta;

  dsi_vtg_cfg #(.H_W(H_W), .V_W(V_W), .P_W(P_W), .ACT_MAX(ACT_MAX)) u_cfg (
    .mode(cfg_mode), .hsa(cfg_hsa), .hbp(cfg_hbp), .hact(cfg_hact), .hline(cfg_hline),
    .vsa(cfg_vsa), .vbp(cfg_vbp), .vact(cfg_vact), .vfp(cfg_vfp), .pixels(cfg_pixels),
    .ok(cfg_ok));

  assign load = enable && cfg_ok && (!running || frame_end);
  assign first_reg = region_pick({cfg_vfp != '0, cfg_vact != '0, cfg_vbp != '0, cfg_vsa != '0}, 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sh_hsa <= '0; sh_hbp <= '0; sh_hact <= '0; sh_hline <= '0;
      sh_vsa <= '0; sh_vbp <= '0; sh_vact <= '0; sh_vfp <= '0;
      sh_pix <= '0; sh_mask <= '0; sh_bta <= 1'b0;
    end else begin
      if (!enable)                     running <= 1'b0;
      else if (!running || frame_end)  running <= cfg_ok;
      if (load) begin
        sh_hsa <= cfg_hsa; sh_hbp <= cfg_hbp; sh_hact <= cfg_hact; sh_hline <= cfg_hline;
        sh_vsa <= cfg_vsa; sh_vbp <= cfg_vbp; sh_vact <= cfg_vact; sh_vfp <= cfg_vfp;
        sh_pix <= cfg_pixels; sh_mask <= cfg_lp_mask; sh_bta <= cfg_bta_ack;
      end
    end
  end

  dsi_vtg_vframe #(.V_W(V_W)) u_vframe (
    .clk(clk), .rst_n(rst_n), .run(running), .load(load), .load_reg(first_reg),
    .line_end(line_end), .vsa(sh_vsa), .vbp(sh_vbp), .vact(sh_vact), .vfp(sh_vfp),
    .vreg(vreg), .frame_end(frame_end), .last_act(last_act), .at_top(at_top),
    .left_sync(left_sync));

  dsi_vtg_hline #(.H_W(H_W)) u_hline (
    .clk(clk), .rst_n(rst_n), .run(running), .in_act(vreg == V_ACT),
    .hsa(sh_hsa), .hbp(sh_hbp), .hact(sh_hact), .hline(sh_hline),
    .hreg(hreg), .line_end(line_end), .hs_start(hs_start), .hs_end(hs_end),
    .pkt_fire(pkt_fire));

  always_comb begin
    lp_raw = 1'b0;
    if (hreg != H_SYNC) begin
      case (vreg)
        V_SYNC:  lp_raw = sh_mask[0];
        V_BACK:  lp_raw = sh_mask[1];
        V_FRONT: lp_raw = sh_mask[2];
        default: begin
          if (hreg == H_BACK)       lp_raw = sh_mask[3];
          else if (hreg == H_FRONT) lp_raw = last_act ? sh_mask[5] : sh_mask[4];
        end
      endcase
    end
  end

  assign active      = running;
  assign cfg_err     = !cfg_ok;
  assign vregion     = running ? vreg : 2'd0;
  assign hregion     = running ? hreg : 2'd0;
  assign line_start  = hs_start;
  assign sync_end    = hs_end;
  assign frame_start = hs_start && at_top;
  assign vsync_end   = hs_start && left_sync;
  assign pkt_valid   = pkt_fire;
  assign pkt_size    = sh_pix;
  assign lp_allowed  = running && lp_raw;
  assign bta_req     = frame_end && sh_bta;

  // R4
  pkt_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (vregion == V_ACT));
  // R5
  lp_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_allowed |-> (hregion != H_SYNC));
  // R6
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && cfg_err) |=> !active);
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !frame_start) |-> ($stable(sh_hline) && $stable(sh_vact)));
  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active);
  // R9
  bta_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bta_req |=> (frame_start || !active));
endmodule

// File: tb/dsi_vid_timing_bench.sv
module dsi_vid_timing_bench;
  localparam int H_W = 12, V_W = 12, P_W = 14;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] c_mode = 2'd2;
  logic [H_W-1:0] c_hsa = '0, c_hbp = '0, c_hact = '0, c_hline = '0;
  logic [V_W-1:0] c_vsa = '0, c_vbp = '0, c_vact = '0, c_vfp = '0;
  logic [P_W-1:0] c_pix = '0;
  logic [5:0] c_mask = '0;
  logic c_bta = 1'b0;
  logic active, cfg_err, line_start, sync_end, frame_start, vsync_end, pkt_valid, lp_allowed, bta_req;
  logic [1:0] vregion, hregion;
  logic [P_W-1:0] pkt_size;
  int n_chk = 0, n_fail = 0;
  int e_hs, e_hb, e_ha, e_hl, e_vs, e_vb, e_va, e_vf, e_pix, e_mask, e_bta;

  always #4 clk = ~clk;

  dsi_vid_timing u_dsi_vid_timing (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(c_mode),
    .cfg_hsa(c_hsa), .cfg_hbp(c_hbp), .cfg_hact(c_hact), .cfg_hline(c_hline),
    .cfg_vsa(c_vsa), .cfg_vbp(c_vbp), .cfg_vact(c_vact), .cfg_vfp(c_vfp),
    .cfg_pixels(c_pix), .cfg_lp_mask(c_mask), .cfg_bta_ack(c_bta),
    .active(active), .cfg_err(cfg_err), .vregion(vregion), .hregion(hregion),
    .line_start(line_start), .sync_end(sync_end), .frame_start(frame_start),
    .vsync_end(vsync_end), .pkt_valid(pkt_valid), .pkt_size(pkt_size),
    .lp_allowed(lp_allowed), .bta_req(bta_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int hs, hb, ha, hl, vs, vb, va, vf, pix, mask, bta);
    c_hsa = H_W'(hs); c_hbp = H_W'(hb); c_hact = H_W'(ha); c_hline = H_W'(hl);
    c_vsa = V_W'(vs); c_vbp = V_W'(vb); c_vact = V_W'(va); c_vfp = V_W'(vf);
    c_pix = P_W'(pix); c_mask = 6'(mask); c_bta = bta[0];
  endtask

  task automatic take_exp();
    e_hs = int'(c_hsa); e_hb = int'(c_hbp); e_ha = int'(c_hact); e_hl = int'(c_hline);
    e_vs = int'(c_vsa); e_vb = int'(c_vbp); e_va = int'(c_vact); e_vf = int'(c_vfp);
    e_pix = int'(c_pix); e_mask = int'(c_mask); e_bta = int'(c_bta);
  endtask

  function automatic int flen();
    return e_hl * (e_vs + e_vb + e_va + e_vf);
  endfunction

  // compare one cycle at frame offset t against the arithmetic timing
  task automatic sample(input int t);
    int line, h, ev, eh, el, es, eb, ep, fl;
    fl = flen();
    line = t / e_hl; h = t % e_hl;
    ev = (line < e_vs) ? 0 : (line < e_vs + e_vb) ? 1 : (line < e_vs + e_vb + e_va) ? 2 : 3;
    eh = (h < e_hs) ? 0 : (h < e_hs + e_hb) ? 1 : (ev == 2 && h < e_hs + e_hb + e_ha) ? 2 : 3;
    ep = (ev == 2 && h == e_hs + e_hb) ? 1 : 0;
    if (eh == 0) el = 0;
    else if (ev == 0) el = e_mask & 1;
    else if (ev == 1) el = (e_mask >> 1) & 1;
    else if (ev == 3) el = (e_mask >> 2) & 1;
    else if (eh == 1) el = (e_mask >> 3) & 1;
    else if (eh == 2) el = 0;
    else el = (line == e_vs + e_vb + e_va - 1) ? ((e_mask >> 5) & 1) : ((e_mask >> 4) & 1);
    es = {28'd0, h == 0, h == e_hs, t == 0, e_vs > 0 && line == e_vs && h == 0};
    eb = (e_bta != 0 && t == fl - 1) ? 1 : 0;
    chk(active && int'(hregion) == eh, "R2", {active, hregion}, 4 | eh);
    chk(int'(vregion) == ev, "R3", int'(vregion), ev);
    chk(int'(pkt_valid) == ep, "R4", int'(pkt_valid), ep);
    if (ep != 0) chk(int'(pkt_size) == e_pix, "R4 size", int'(pkt_size), e_pix);
    chk(int'(lp_allowed) == el, "R5", int'(lp_allowed), el);
    chk(int'({line_start, sync_end, frame_start, vsync_end}) == es, "R10",
        int'({line_start, sync_end, frame_start, vsync_end}), es);
    chk(int'(bta_req) == eb, "R9", int'(bta_req), eb);
  endtask

  task automatic span(input int t0, input int n);
    for (int k = 0; k < n; k++) begin
      sample((t0 + k) % flen());
      @(negedge clk);
    end
  endtask

  // stop, apply present c_* and start; returns at negedge with frame offset 0
  task automatic restart();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    take_exp();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk({active, vregion, hregion, line_start, sync_end, frame_start, vsync_end,
         pkt_valid, lp_allowed, bta_req} == '0, "R1", int'(active), 0);

    // R2 R3 R4 R5 R9 R10: sweep of small configurations, two frames each
    for (int i = 0; i < 64; i++) begin
      set_cfg(i & 1, ((i >> 1) & 1) * 2, 2, (i & 1) + ((i >> 1) & 1) * 2 + 4,
              (i >> 2) & 1, ((i >> 3) & 1) * 2, 1 + ((i >> 5) & 1), (i >> 4) & 1,
              100 + i, (i * 13 + 5) & 63, (i % 3 == 0) ? 1 : 0);
      restart();
      span(0, 2 * flen());
    end

    // R3: no active lines at all, and only active lines
    set_cfg(1, 1, 1, 5, 1, 0, 0, 2, 7, 63, 1);
    restart(); span(0, 2 * flen());
    set_cfg(0, 1, 3, 6, 0, 0, 3, 0, 9, 42, 0);
    restart(); span(0, 2 * flen());

    // R7: change mid-frame, new values from next frame only
    set_cfg(1, 1, 2, 6, 1, 1, 2, 1, 20, 21, 0);
    restart();
    span(0, 5);
    set_cfg(2, 0, 1, 5, 0, 2, 1, 2, 33, 50, 1);
    span(5, flen() - 5);
    take_exp();
    span(0, flen());

    // R8: disable mid-frame, idle next cycle, restart at frame top
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!active && vregion == 2'd0 && !line_start, "R8 idle", int'(active), 0);
    enable = 1'b1;
    take_exp();
    @(negedge clk);
    span(0, flen());

    // R6: refused configurations
    set_cfg(1, 1, 2, 6, 1, 1, 12'h800, 1, 5, 0, 0);
    restart();
    chk(cfg_err && !active, "R6 vact", {cfg_err, active}, 2);
    set_cfg(1, 1, 2, 6, 1, 1, 2, 1, 14'h800, 0, 0);
    restart();
    chk(cfg_err && !active, "R6 pixels", {cfg_err, active}, 2);
    set_cfg(1, 1, 2, 4, 1, 1, 2, 1, 5, 0, 0);
    restart();
    chk(cfg_err && !active, "R6 hline", {cfg_err, active}, 2);
    set_cfg(1, 1, 0, 6, 1, 1, 2, 1, 5, 0, 0);
    restart();
    chk(cfg_err && !active, "R6 hact", {cfg_err, active}, 2);
    set_cfg(1, 1, 2, 6, 0, 0, 0, 0, 5, 0, 0);
    restart();
    chk(cfg_err && !active, "R6 nolines", {cfg_err, active}, 2);
    set_cfg(1, 1, 2, 6, 1, 1, 2, 1, 5, 0, 0);
    c_mode = 2'd1;
    restart();
    chk(cfg_err && !active, "R6 mode", {cfg_err, active}, 2);
    c_mode = 2'd2;
    set_cfg(1, 1, 2, 6, 1, 0, 12'h7FF, 0, 14'h7FF, 0, 0);
    restart();
    chk(!cfg_err && active, "R6 limit", {cfg_err, active}, 1);
    // refused at a frame boundary sends the generator idle
    set_cfg(1, 1, 2, 5, 1, 1, 1, 1, 8, 0, 0);
    restart();
    span(0, 3);
    c_vact = 12'h900;
    span(3, flen() - 3);
    chk(!active, "R6 boundary", int'(active), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule